// File: doc/BRIEF.md
# Video pixels-per-clock stream remapper

This block takes a video stream whose beats carry a run-time selected number of pixels (1, 2 or 4) and re-emits the same pixels, in the same order, on an output stream whose beats carry a separately selected number of pixels. A small register file on a simplified AXI4-Lite control port holds the frame geometry, a colour format code, the two pixel-per-beat settings and two enable bits that are kept only for software compatibility. All three interfaces share one clock.

Inside, the input beats are unpacked and gathered into 4-pixel groups, which is the common multiple of every supported count. A second stage then slices each group into output beats of the requested size. The output start-of-frame (`tuser`) and end-of-line (`tlast`) markers are not copied from the input. They are rebuilt from the programmed width and height. Software programs the geometry and both counts before a frame starts, and leaves them unchanged while the frame is in flight. The width must be a multiple of both pixel counts.

Top module: `vid_ppc_remap`

## Requirements
- R1: After a synchronous active-low reset, the colour format register reads 1 and every other register reads 0. The output stream is idle (`m_tvalid` low).
- R2: Register map: height at 0x10 and width at 0x18 hold 16 bits; colour format at 0x20, input count at 0x28 and output count at 0x30 hold 8 bits; the drop enable at 0x48 and repeat enable at 0x50 hold bit 0. Higher written bits read back as 0, and any other address reads 0. A write is acknowledged with `bvalid` the cycle after it is accepted. A read returns `rvalid` with the data the cycle after the address is accepted.
- R3: Each accepted input beat carries N pixels, where N is the input count. Pixel i sits in bits [24i+23:24i], and lanes at or above N are ignored. Counts 2 and 4 are taken as written, and any other value is treated as 1.
- R4: Each output beat carries M pixels, where M is the output count, decoded the same way, in lanes 0..M-1 in stream order. Lanes at or above M are driven to 0.
- R5: Under any pattern of stalls on either stream, every input pixel appears on the output exactly once and in order.
- R6: `m_tuser` is high on the first output beat of every frame and low on every other beat.
- R7: `m_tlast` is high on the last beat of every line, which is every width/M beats.
- R8: A frame whose pixel count is not a multiple of 4 is emitted completely, and the next frame starts in a fresh group.
- R9: The drop and repeat enable bits have no effect on the output stream.
- R10: While `m_tvalid` is high and `m_tready` is low, the output data and markers hold their values and `m_tvalid` stays high.
- R11: With 4 pixels in and 4 out and no stalls, the block sustains one output beat per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for control and both streams |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_awaddr | input | 8 | Write address |
| ctl_awvalid | input | 1 | Write address valid |
| ctl_awready | output | 1 | Write address accepted |
| ctl_wdata | input | 32 | Write data |
| ctl_wvalid | input | 1 | Write data valid |
| ctl_wready | output | 1 | Write data accepted |
| ctl_bvalid | output | 1 | Write response valid |
| ctl_bready | input | 1 | Write response taken |
| ctl_araddr | input | 8 | Read address |
| ctl_arvalid | input | 1 | Read address valid |
| ctl_arready | output | 1 | Read address accepted |
| ctl_rdata | output | 32 | Read data |
| ctl_rvalid | output | 1 | Read data valid |
| ctl_rready | input | 1 | Read data taken |
| s_tdata | input | 96 | Input pixel lanes, 24 bits each |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| m_tdata | output | 96 | Output pixel lanes, 24 bits each |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat taken |
| m_tuser | output | 1 | First beat of a frame |
| m_tlast | output | 1 | Last beat of a line |

## Verification
The bench builds the block with the package defaults: 24-bit pixels and four lanes. These defaults give every pairing of the counts 1, 2 and 4, including the pass-through cases. They also allow frame sizes whose pixel count leaves a partial 4-pixel group, which is what makes the end-of-frame flush and the fresh group at the next frame reachable. Upper lanes are filled with nonzero filler so that both lane masking on the input and lane zeroing on the output are visible at the ports.

// File: rtl/vppc_pkg.sv
package vppc_pkg;
    parameter int unsigned PIX_BITS      = 24;
    parameter int unsigned LANES         = 4;
    parameter int unsigned DIM_BITS      = 16;
    parameter int unsigned CSR_ADDR_BITS = 8;
    parameter int unsigned CSR_DATA_BITS = 32;

    localparam int unsigned BUS_BITS   = PIX_BITS * LANES;
    localparam int unsigned CNT_BITS   = $clog2(LANES + 1);
    localparam int unsigned FRAME_BITS = 2 * DIM_BITS;

    localparam logic [CSR_ADDR_BITS-1:0] A_HEIGHT = 8'h10;
    localparam logic [CSR_ADDR_BITS-1:0] A_WIDTH  = 8'h18;
    localparam logic [CSR_ADDR_BITS-1:0] A_FORMAT = 8'h20;
    localparam logic [CSR_ADDR_BITS-1:0] A_IN_PPC = 8'h28;
    localparam logic [CSR_ADDR_BITS-1:0] A_OUT_PPC = 8'h30;
    localparam logic [CSR_ADDR_BITS-1:0] A_DROP   = 8'h48;
    localparam logic [CSR_ADDR_BITS-1:0] A_REPEAT = 8'h50;

    localparam logic [7:0] FMT_RESET = 8'd1;

    typedef logic [CNT_BITS-1:0] lane_cnt_t;

    // one gathered group of pixels handed from the widening to the narrowing stage
    typedef struct packed {
        lane_cnt_t           cnt;
        logic [BUS_BITS-1:0] pix;
    } group_t;

    // register value -> pixels per beat; unsupported codes fall back to one
    function automatic lane_cnt_t ppc_decode(input logic [7:0] raw);
        if (raw == 8'd4 && LANES >= 4)      return lane_cnt_t'(4);
        else if (raw == 8'd2 && LANES >= 2) return lane_cnt_t'(2);
        else                                return lane_cnt_t'(1);
    endfunction

    function automatic logic [1:0] ppc_shift(input lane_cnt_t c);
        if (c == lane_cnt_t'(4))      return 2'd2;
        else if (c == lane_cnt_t'(2)) return 2'd1;
        else                          return 2'd0;
    endfunction
endpackage

// File: rtl/vppc_csr.sv
module vppc_csr
    import vppc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CSR_ADDR_BITS-1:0] awaddr,
    input  logic                     awvalid,
    output logic                     awready,
    input  logic [CSR_DATA_BITS-1:0] wdata,
    input  logic                     wvalid,
    output logic                     wready,
    output logic                     bvalid,
    input  logic                     bready,
    input  logic [CSR_ADDR_BITS-1:0] araddr,
    input  logic                     arvalid,
    output logic                     arready,
    output logic [CSR_DATA_BITS-1:0] rdata,
    output logic                     rvalid,
    input  logic                     rready,
    output logic [DIM_BITS-1:0]      height,
    output logic [DIM_BITS-1:0]      width,
    output logic [7:0]               in_ppc_raw,
    output logic [7:0]               out_ppc_raw
);
    logic [7:0]               fmt_q;
    logic                     drop_q;
    logic                     rep_q;
    logic                     wr_go;
    logic                     rd_go;
    logic [CSR_DATA_BITS-1:0] rd_word;
    logic                     unused_wbits;

    assign unused_wbits = &{1'b0, wdata[CSR_DATA_BITS-1:DIM_BITS]};

    assign wr_go   = awvalid && wvalid && !bvalid;
    assign awready = wr_go;
    assign wready  = wr_go;
    assign arready = !rvalid;
    assign rd_go   = arvalid && arready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            height      <= '0;
            width       <= '0;
            fmt_q       <= FMT_RESET;
            in_ppc_raw  <= '0;
            out_ppc_raw <= '0;
            drop_q      <= 1'b0;
            rep_q       <= 1'b0;
            bvalid      <= 1'b0;
        end else begin
            if (wr_go) begin
                case (awaddr)
                    A_HEIGHT:  height      <= wdata[DIM_BITS-1:0];
                    A_WIDTH:   width       <= wdata[DIM_BITS-1:0];
                    A_FORMAT:  fmt_q       <= wdata[7:0];
                    A_IN_PPC:  in_ppc_raw  <= wdata[7:0];
                    A_OUT_PPC: out_ppc_raw <= wdata[7:0];
                    A_DROP:    drop_q      <= wdata[0];
                    A_REPEAT:  rep_q       <= wdata[0];
                    default: ;
                endcase
                bvalid <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_word = '0;
        case (araddr)
            A_HEIGHT:  rd_word[DIM_BITS-1:0] = height;
            A_WIDTH:   rd_word[DIM_BITS-1:0] = width;
            A_FORMAT:  rd_word[7:0]          = fmt_q;
            A_IN_PPC:  rd_word[7:0]          = in_ppc_raw;
            A_OUT_PPC: rd_word[7:0]          = out_ppc_raw;
            A_DROP:    rd_word[0]            = drop_q;
            A_REPEAT:  rd_word[0]            = rep_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

    // R2: write acknowledged one cycle after acceptance
    p_write_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && awready && wvalid && wready) |=> bvalid);
    // R2: read data presented one cycle after address acceptance
    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && arready) |=> rvalid);
endmodule

// File: rtl/vppc_widen.sv
module vppc_widen
    import vppc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  lane_cnt_t             in_ppc,
    input  logic [FRAME_BITS-1:0] frame_pix,
    input  logic [BUS_BITS-1:0]   s_tdata,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    output group_t                grp,
    output logic                  grp_valid,
    input  logic                  grp_take
);
    logic [BUS_BITS-1:0]   acc_pix;
    logic [BUS_BITS-1:0]   merged;
    lane_cnt_t             acc_cnt;
    logic                  acc_full;
    logic [FRAME_BITS-1:0] frame_cnt;
    logic [FRAME_BITS-1:0] frame_next;
    logic [CNT_BITS:0]     base_cnt;
    logic [CNT_BITS:0]     new_cnt;
    logic                  frame_end;
    logic                  in_fire;

    assign s_tready   = !acc_full || grp_take;
    assign in_fire    = s_tvalid && s_tready;
    assign base_cnt   = acc_full ? '0 : {1'b0, acc_cnt};
    assign new_cnt    = base_cnt + {1'b0, in_ppc};
    assign frame_next = frame_cnt + FRAME_BITS'(in_ppc);
    assign frame_end  = (frame_pix != '0) && (frame_next >= frame_pix);

    // place the beat's low lanes after the pixels already gathered
    always_comb begin
        merged = acc_pix;
        for (int l = 0; l < LANES; l++) begin
            if (l >= int'(base_cnt) && l < int'(new_cnt)) begin
                merged[l*PIX_BITS +: PIX_BITS] =
                    s_tdata[(l - int'(base_cnt))*PIX_BITS +: PIX_BITS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_pix   <= '0;
            acc_cnt   <= '0;
            acc_full  <= 1'b0;
            frame_cnt <= '0;
        end else if (in_fire) begin
            acc_pix   <= merged;
            acc_cnt   <= lane_cnt_t'(new_cnt);
            acc_full  <= (new_cnt >= (CNT_BITS+1)'(LANES)) || frame_end;
            frame_cnt <= frame_end ? '0 : frame_next;
        end else if (grp_take) begin
            acc_full <= 1'b0;
            acc_cnt  <= '0;
        end
    end

    assign grp.cnt   = acc_cnt;
    assign grp.pix   = acc_pix;
    assign grp_valid = acc_full;

    // R5: a beat never spills past the group, so no pixel is lost
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> (new_cnt <= (CNT_BITS+1)'(LANES)));
endmodule

// File: rtl/vppc_narrow.sv
module vppc_narrow
    import vppc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  lane_cnt_t           out_ppc,
    input  logic [DIM_BITS-1:0] width,
    input  logic [DIM_BITS-1:0] height,
    input  group_t              grp,
    input  logic                grp_valid,
    output logic                grp_take,
    output logic [BUS_BITS-1:0] m_tdata,
    output logic                m_tvalid,
    input  logic                m_tready,
    output logic                m_tuser,
    output logic                m_tlast
);
    logic [BUS_BITS-1:0] hold_pix;
    lane_cnt_t           hold_cnt;
    lane_cnt_t           hold_rd;
    logic                hold_valid;
    logic                m_fire;
    logic                last_slice;
    logic [CNT_BITS:0]   rd_end;
    logic [DIM_BITS-1:0] beats_per_line;
    logic [DIM_BITS-1:0] xpos;
    logic [DIM_BITS-1:0] ypos;
    logic                last_row;

    assign m_fire     = hold_valid && m_tready;
    assign rd_end     = {1'b0, hold_rd} + {1'b0, out_ppc};
    assign last_slice = rd_end >= {1'b0, hold_cnt};
    assign grp_take   = grp_valid && (!hold_valid || (m_fire && last_slice));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_pix   <= '0;
            hold_cnt   <= '0;
            hold_rd    <= '0;
            hold_valid <= 1'b0;
        end else if (grp_take) begin
            hold_pix   <= grp.pix;
            hold_cnt   <= grp.cnt;
            hold_rd    <= '0;
            hold_valid <= 1'b1;
        end else if (m_fire) begin
            if (last_slice) hold_valid <= 1'b0;
            else            hold_rd    <= lane_cnt_t'(rd_end);
        end
    end

    // slice out_ppc pixels starting at the read position; upper lanes zero
    always_comb begin
        m_tdata = '0;
        for (int l = 0; l < LANES; l++) begin
            if (l < int'(out_ppc) && (int'(hold_rd) + l) < LANES) begin
                m_tdata[l*PIX_BITS +: PIX_BITS] =
                    hold_pix[(int'(hold_rd) + l)*PIX_BITS +: PIX_BITS];
            end
        end
    end

    assign m_tvalid = hold_valid;

    // frame position counters that rebuild the markers
    assign beats_per_line = width >> ppc_shift(out_ppc);
    assign last_row       = (ypos == height - 1'b1);
    assign m_tuser        = (xpos == '0) && (ypos == '0);
    assign m_tlast        = (xpos == beats_per_line - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xpos <= '0;
            ypos <= '0;
        end else if (m_fire) begin
            if (m_tlast) begin
                xpos <= '0;
                ypos <= last_row ? '0 : ypos + 1'b1;
            end else begin
                xpos <= xpos + 1'b1;
            end
        end
    end

    // R10: a stalled beat stays put
    p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)
                                     && $stable(m_tuser) && $stable(m_tlast)));
    // R6: the beat after a frame's final beat starts the next frame
    p_frame_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_fire && m_tlast && last_row) |=> m_tuser);
endmodule

// File: rtl/vid_ppc_remap.sv
module vid_ppc_remap
    import vppc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CSR_ADDR_BITS-1:0] ctl_awaddr,
    input  logic                     ctl_awvalid,
    output logic                     ctl_awready,
    input  logic [CSR_DATA_BITS-1:0] ctl_wdata,
    input  logic                     ctl_wvalid,
    output logic                     ctl_wready,
    output logic                     ctl_bvalid,
    input  logic                     ctl_bready,
    input  logic [CSR_ADDR_BITS-1:0] ctl_araddr,
    input  logic                     ctl_arvalid,
    output logic                     ctl_arready,
    output logic [CSR_DATA_BITS-1:0] ctl_rdata,
    output logic                     ctl_rvalid,
    input  logic                     ctl_rready,
    input  logic [BUS_BITS-1:0]      s_tdata,
    input  logic                     s_tvalid,
    output logic                     s_tready,
    output logic [BUS_BITS-1:0]      m_tdata,
    output logic                     m_tvalid,
    input  logic                     m_tready,
    output logic                     m_tuser,
    output logic                     m_tlast
);
    logic [DIM_BITS-1:0]   height;
    logic [DIM_BITS-1:0]   width;
    logic [7:0]            in_raw;
    logic [7:0]            out_raw;
    lane_cnt_t             in_ppc;
    lane_cnt_t             out_ppc;
    logic [FRAME_BITS-1:0] frame_pix;
    group_t                grp;
    logic                  grp_valid;
    logic                  grp_take;

    vppc_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .awaddr     (ctl_awaddr),
        .awvalid    (ctl_awvalid),
        .awready    (ctl_awready),
        .wdata      (ctl_wdata),
        .wvalid     (ctl_wvalid),
        .wready     (ctl_wready),
        .bvalid     (ctl_bvalid),
        .bready     (ctl_bready),
        .araddr     (ctl_araddr),
        .arvalid    (ctl_arvalid),
        .arready    (ctl_arready),
        .rdata      (ctl_rdata),
        .rvalid     (ctl_rvalid),
        .rready     (ctl_rready),
        .height     (height),
        .width      (width),
        .in_ppc_raw (in_raw),
        .out_ppc_raw(out_raw)
    );

    assign in_ppc    = ppc_decode(in_raw);
    assign out_ppc   = ppc_decode(out_raw);
    assign frame_pix = FRAME_BITS'(width) * FRAME_BITS'(height);

    vppc_widen u_widen (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_ppc   (in_ppc),
        .frame_pix(frame_pix),
        .s_tdata  (s_tdata),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .grp      (grp),
        .grp_valid(grp_valid),
        .grp_take (grp_take)
    );

    vppc_narrow u_narrow (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_ppc  (out_ppc),
        .width    (width),
        .height   (height),
        .grp      (grp),
        .grp_valid(grp_valid),
        .grp_take (grp_take),
        .m_tdata  (m_tdata),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready),
        .m_tuser  (m_tuser),
        .m_tlast  (m_tlast)
    );
endmodule

// File: tb/vid_ppc_remap_tb_top.sv
module vid_ppc_remap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic        bvalid;
    logic        bready = 1'b1;
    logic [7:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic        rvalid;
    logic        rready = 1'b1;
    logic [95:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [95:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic        m_tuser;
    logic        m_tlast;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vid_ppc_remap dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_awaddr(awaddr), .ctl_awvalid(awvalid), .ctl_awready(awready),
        .ctl_wdata(wdata), .ctl_wvalid(wvalid), .ctl_wready(wready),
        .ctl_bvalid(bvalid), .ctl_bready(bready),
        .ctl_araddr(araddr), .ctl_arvalid(arvalid), .ctl_arready(arready),
        .ctl_rdata(rdata), .ctl_rvalid(rvalid), .ctl_rready(rready),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [7:0] a, input logic [31:0] d);
        bit ok;
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        do begin
            #4 ok = awready && wready;
            @(negedge clk);
        end while (!ok);
        awvalid = 1'b0; wvalid = 1'b0;
        check(bvalid, "R2", "write response", 128'(bvalid), 128'(1));
        @(negedge clk);
    endtask

    task automatic csr_read(input logic [7:0] a, output logic [31:0] d);
        bit ok;
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        do begin
            #4 ok = arready;
            @(negedge clk);
        end while (!ok);
        arvalid = 1'b0;
        check(rvalid, "R2", "read valid", 128'(rvalid), 128'(1));
        d = rdata;
        @(negedge clk);
    endtask

    function automatic logic [23:0] pix(input int k, input int seed);
        return 24'(k * 37 + seed * 4096 + 1);
    endfunction

    // stream 'frames' frames and check every output beat as it leaves
    task automatic run_stream(input int in_raw, input int in_n, input int out_raw,
                              input int out_n, input int w, input int h,
                              input int frames, input int stall_in, input int stall_out,
                              input int seed, input string req, output int cycles);
        int total_pix, total_beats, sent, got, base;
        bit fired, prev_stall, prev_user, prev_last;
        logic [95:0] beat, expd, prev_data;
        csr_write(8'h10, 32'(h));
        csr_write(8'h18, 32'(w));
        csr_write(8'h28, 32'(in_raw));
        csr_write(8'h30, 32'(out_raw));
        total_pix = w * h * frames;
        total_beats = total_pix / out_n;
        sent = 0; got = 0; cycles = 0; fired = 0; prev_stall = 0;
        prev_user = 0; prev_last = 0; prev_data = '0;
        while (got < total_beats && cycles < 20000) begin
            @(negedge clk);
            if (!s_tvalid || fired) begin
                if (sent < total_pix && ($urandom % 100) >= 32'(stall_in)) begin
                    for (int l = 0; l < 4; l++)
                        beat[l*24 +: 24] = (l < in_n) ? pix(sent + l, seed)
                                                      : (24'hDEAD00 | 24'(l + 1));
                    s_tdata = beat;
                    s_tvalid = 1'b1;
                end else begin
                    s_tvalid = 1'b0;
                end
            end
            m_tready = ($urandom % 100) >= 32'(stall_out);
            #4;
            if (prev_stall)
                check(m_tvalid && m_tdata == prev_data && m_tuser == prev_user
                      && m_tlast == prev_last, "R10", {req, " stalled beat held"},
                      128'(m_tdata), 128'(prev_data));
            fired = s_tvalid && s_tready;
            if (fired) sent += in_n;
            if (m_tvalid && m_tready) begin
                base = got * out_n;
                expd = '0;
                for (int l = 0; l < 4; l++)
                    if (l < out_n) expd[l*24 +: 24] = pix(base + l, seed);
                check(m_tdata == expd, "R3 R4 R5", {req, " beat data"},
                      128'(m_tdata), 128'(expd));
                check(m_tuser == ((base % (w * h)) == 0), "R6", {req, " tuser"},
                      128'(m_tuser), 128'((base % (w * h)) == 0));
                check(m_tlast == (((base + out_n) % w) == 0), "R7", {req, " tlast"},
                      128'(m_tlast), 128'(((base + out_n) % w) == 0));
                got++;
            end
            prev_stall = m_tvalid && !m_tready;
            prev_data = m_tdata; prev_user = m_tuser; prev_last = m_tlast;
            cycles++;
        end
        @(negedge clk);
        if (fired) s_tvalid = 1'b0;
        m_tready = 1'b1;
        check(got == total_beats && sent == total_pix, "R5", {req, " beat count"},
              128'(got), 128'(total_beats));
        repeat (4) @(negedge clk);
        #4;
        check(!m_tvalid, "R5", {req, " no extra beats"}, 128'(m_tvalid), 128'(0));
        s_tvalid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        logic [7:0] addrs[7] = '{8'h10, 8'h18, 8'h20, 8'h28, 8'h30, 8'h48, 8'h50};
        check(!m_tvalid, "R1", "output idle after reset", 128'(m_tvalid), 128'(0));
        foreach (addrs[i]) begin
            csr_read(addrs[i], d);
            check(d == ((addrs[i] == 8'h20) ? 32'd1 : 32'd0), "R1", "reset value",
                  128'(d), 128'((addrs[i] == 8'h20) ? 1 : 0));
        end
    endtask

    task automatic t_csr_fields();
        logic [31:0] d;
        csr_write(8'h10, 32'hFFFF_FFFF);
        csr_read(8'h10, d);
        check(d == 32'h0000_FFFF, "R2", "height field width", 128'(d), 128'(32'hFFFF));
        csr_write(8'h20, 32'h0000_0303);
        csr_read(8'h20, d);
        check(d == 32'h0000_0003, "R2", "format field width", 128'(d), 128'(3));
        csr_write(8'h48, 32'hFFFF_FFFF);
        csr_read(8'h48, d);
        check(d == 32'd1, "R2", "drop bit", 128'(d), 128'(1));
        csr_write(8'h44, 32'h1234_5678);
        csr_read(8'h44, d);
        check(d == 32'd0, "R2", "unmapped address", 128'(d), 128'(0));
        csr_write(8'h48, 32'd0);
        csr_write(8'h20, 32'd1);
    endtask

    task automatic t_mixed_rates();
        int c;
        run_stream(1, 1, 4, 4, 8, 3, 2, 30, 30, 1, "in1 out4", c);
        run_stream(4, 4, 1, 1, 8, 2, 2, 20, 50, 2, "in4 out1", c);
        run_stream(2, 2, 4, 4, 4, 3, 1, 25, 25, 3, "in2 out4", c);
        run_stream(4, 4, 2, 2, 12, 2, 1, 0, 70, 4, "in4 out2", c);
        run_stream(2, 2, 1, 1, 6, 2, 1, 40, 10, 5, "in2 out1", c);
    endtask

    task automatic t_partial_groups();
        int c;
        // R8: 6-pixel frames leave a 2-pixel group at each frame end
        run_stream(1, 1, 2, 2, 6, 1, 3, 20, 20, 6, "R8 in1 out2", c);
        run_stream(2, 2, 2, 2, 2, 3, 2, 30, 30, 7, "R8 in2 out2", c);
    endtask

    task automatic t_unsupported_code();
        int c;
        // R3: count code 3 behaves as one pixel per beat
        run_stream(3, 1, 4, 4, 4, 2, 1, 10, 10, 8, "R3 code3", c);
    endtask

    task automatic t_drop_repeat_inert();
        int c;
        logic [31:0] d;
        csr_write(8'h48, 32'd1);
        csr_write(8'h50, 32'd1);
        csr_read(8'h50, d);
        check(d == 32'd1, "R2", "repeat bit", 128'(d), 128'(1));
        run_stream(2, 2, 1, 1, 4, 2, 1, 20, 20, 9, "R9 enables set", c);
        csr_write(8'h48, 32'd0);
        csr_write(8'h50, 32'd0);
    endtask

    task automatic t_throughput();
        int c;
        run_stream(4, 4, 4, 4, 16, 4, 1, 0, 0, 10, "R11 4to4", c);
        check(c <= 16 + 4, "R11", "cycles for 16 beats", 128'(c), 128'(20));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        t_reset();
        t_csr_fields();
        t_mixed_rates();
        t_partial_groups();
        t_unsupported_code();
        t_drop_repeat_inert();
        t_throughput();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule